// File: doc/BRIEF.md
# Dual-Slope PWM Timer with Buffered Period

This block is a 16-bit timer that counts up from zero to a period limit (TOP) and then back down to zero. It drives two waveform outputs, A and B. Each output is compared with its own compare value and can change on the rising slope and on the falling slope. Because the count runs symmetrically about TOP, the pulses stay centred in each period. The output frequency is the clock rate divided by 2 × N × TOP, where N is the division of the external clock-enable source.

TOP comes from one of two places. It can be a dedicated period register, which suits a fixed period, or it can be compare value A, which suits a period that changes while the timer runs. Software writes go into shadow registers. The values in use change only at the point where the count is zero, so a period is never cut short or made uneven. Output A can also run as a 50% square wave: it toggles at each TOP while compare A sets the period.

Each output has a 2-bit mode field:

| Mode | Behaviour |
|---|---|
| 0 | Disconnected |
| 1 | Toggle |
| 2 | Non-inverted PWM |
| 3 | Inverted PWM |

The clock divider sits outside the block and drives the `tick` input.

Top module: `pwm_dual_slope`

## Requirements
- R1: After reset both outputs are low, the counter is zero and counting up, the period register holds all ones, both compare values are zero and both modes are 0. With these values, ticks leave both outputs low.
- R2: On each clock with `tick` high the counter takes one step through 0,1,…,TOP,TOP−1,…,1,0,1,…. It reverses at TOP and at zero without repeating either end value, so one period is 2×TOP ticks. With `tick` low, the counter, the direction and the outputs hold.
- R3: A write with `wr_en` high stores `wr_data` in the shadow register picked by `wr_sel`. Code 0 is the period register, 1 is compare A, 2 is compare B and 3 is control. In control, bits [1:0] are the mode of A, bits [3:2] are the mode of B, and bit 4 selects TOP from compare A when 1 or from the period register when 0.
- R4: In mode 2 an output goes low on a tick where the count equals its compare value while rising. It goes high on such a tick while falling. Over one period it is high for 2×compare ticks.
- R5: In mode 3 the levels of R4 are swapped. Over one period the output is high for 2×(TOP−compare) ticks.
- R6: In mode 2, a compare value of zero holds the output low and a compare value equal to TOP holds it high. In mode 3 the levels are the reverse.
- R7: When TOP comes from compare A and A's mode is 1, output A toggles at every TOP. It is a square wave with a period of 4×TOP ticks and 50% duty.
- R8: Values written to the shadow registers take effect on the tick at which the count is zero. They govern matches from the next tick on.
- R9: An output holds its level when its mode is 0. It also holds in mode 1 unless it is output A with TOP taken from compare A, and output A holds in modes 2 and 3 while TOP comes from compare A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable from the external divider |
| wr_en | input | 1 | Write strobe for the shadow registers |
| wr_sel | input | 2 | Shadow register select (see R3) |
| wr_data | input | 16 | Write data |
| wave_a | output | 1 | Waveform output A |
| wave_b | output | 1 | Waveform output B |

## Verification
A wrong count or direction shows up within one period as a wrong duty: the number of high ticks in a 2×TOP window is not 2×compare. A wrong reversal shows up as an edge that comes one or more ticks early or late, and the bench checks edge timing to the exact tick. A shadow value that goes live too early moves the first output edge after the write to an earlier tick within the same period. A counter that keeps running while `tick` is low shifts every later edge by a measurable number of ticks.

// File: rtl/pwm_ds_pkg.sv
package pwm_ds_pkg;

    typedef enum logic [1:0] {
        OM_OFF      = 2'd0,
        OM_TOGGLE   = 2'd1,
        OM_CLEAR_UP = 2'd2,
        OM_SET_UP   = 2'd3
    } outmode_e;

    localparam logic [1:0] SEL_PERIOD = 2'd0;
    localparam logic [1:0] SEL_CMP_A  = 2'd1;
    localparam logic [1:0] SEL_CMP_B  = 2'd2;
    localparam logic [1:0] SEL_CTRL   = 2'd3;

    typedef struct packed {
        logic       top_src;
        logic [1:0] mode_b;
        logic [1:0] mode_a;
    } ctrl_t;

    localparam int CTRL_BITS = $bits(ctrl_t);

endpackage

// File: rtl/pwm_ds_regs.sv
module pwm_ds_regs
    import pwm_ds_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         load,
    output logic [W-1:0] top,
    output logic [W-1:0] cmp_a,
    output logic [W-1:0] cmp_b,
    output ctrl_t        ctrl
);

    typedef struct packed {
        logic [W-1:0] period;
        logic [W-1:0] ca;
        logic [W-1:0] cb;
        ctrl_t        ct;
    } bank_t;

    typedef struct packed {
        bank_t shadow;
        bank_t live;
    } regs_t;

    localparam bank_t BANK_RST = '{period: {W{1'b1}}, ca: '0, cb: '0, ct: '0};

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_PERIOD: r_d.shadow.period = wr_data;
                SEL_CMP_A:  r_d.shadow.ca     = wr_data;
                SEL_CMP_B:  r_d.shadow.cb     = wr_data;
                default:    r_d.shadow.ct     = ctrl_t'(wr_data[CTRL_BITS-1:0]);
            endcase
        end
        if (load) begin
            r_d.live = r_q.shadow;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{shadow: BANK_RST, live: BANK_RST};
        end else begin
            r_q <= r_d;
        end
    end

    assign top   = r_q.live.ct.top_src ? r_q.live.ca : r_q.live.period;
    assign cmp_a = r_q.live.ca;
    assign cmp_b = r_q.live.cb;
    assign ctrl  = r_q.live.ct;

    AST_LIVE_ONLY_AT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(r_q.live)); // R8

endmodule

// File: rtl/pwm_ds_counter.sv
module pwm_ds_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] top,
    output logic [W-1:0] cnt,
    output logic         head_up,
    output logic         bottom_tick
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         up;
    } cnt_t;

    cnt_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        head_up = s_q.up;
        if (tick) begin
            if (top == '0) begin
                s_d.cnt = '0;
                s_d.up  = 1'b1;
                head_up = 1'b1;
            end else if (s_q.up) begin
                if (s_q.cnt >= top) begin
                    s_d.cnt = s_q.cnt - ONE;
                    s_d.up  = 1'b0;
                    head_up = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt + ONE;
                end
            end else begin
                if (s_q.cnt == '0) begin
                    s_d.cnt = ONE;
                    s_d.up  = 1'b1;
                    head_up = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - ONE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{cnt: '0, up: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt         = s_q.cnt;
    assign bottom_tick = tick && (s_q.cnt == '0);

    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(s_q)); // R2

    AST_TURN_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && s_q.up && top != '0 && s_q.cnt == top) |=> (!s_q.up && s_q.cnt == $past(top) - ONE)); // R2

    AST_TURN_AT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !s_q.up && s_q.cnt == '0 && top != '0) |=> (s_q.up && s_q.cnt == ONE)); // R2

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (top != '0) |-> (s_q.cnt <= top)); // R2

endmodule

// File: rtl/pwm_ds_wave.sv
module pwm_ds_wave
    import pwm_ds_pkg::*;
#(
    parameter int W    = 16,
    parameter bit IS_A = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    input  logic [1:0]   mode,
    input  logic         top_from_a,
    input  logic         head_up,
    output logic         wave
);

    typedef struct packed {
        logic lvl;
    } wave_t;

    wave_t    w_d, w_q;
    logic     hit;
    logic     toggle_ok;
    outmode_e m;

    assign hit       = tick && (cnt == cmp);
    assign toggle_ok = IS_A && top_from_a;
    assign m         = outmode_e'(mode);

    always_comb begin
        w_d = w_q;
        if (hit) begin
            case (m)
                OM_TOGGLE:   if (toggle_ok)  w_d.lvl = !w_q.lvl;
                OM_CLEAR_UP: if (!toggle_ok) w_d.lvl = !head_up;
                OM_SET_UP:   if (!toggle_ok) w_d.lvl = head_up;
                default:     w_d = w_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '{lvl: 1'b0};
        end else begin
            w_q <= w_d;
        end
    end

    assign wave = w_q.lvl;

    AST_MODE_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |=> $stable(w_q)); // R9

    AST_CHANGE_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && cnt == cmp) |=> $stable(w_q)); // R4

    AST_ZERO_CMP_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp == '0 && mode == 2'd2 && !w_q.lvl) |=> !w_q.lvl); // R6

endmodule

// File: rtl/pwm_dual_slope.sv
module pwm_dual_slope
    import pwm_ds_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    output logic         wave_a,
    output logic         wave_b
);

    localparam int NCH = 2;

    logic [W-1:0] top;
    logic [W-1:0] cmp_a;
    logic [W-1:0] cmp_b;
    ctrl_t        ctrl;
    logic [W-1:0] cnt;
    logic         head_up;
    logic         bottom_tick;

    logic [W-1:0] ch_cmp  [NCH];
    logic [1:0]   ch_mode [NCH];
    logic [NCH-1:0] ch_wave;

    pwm_ds_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .load    (bottom_tick),
        .top     (top),
        .cmp_a   (cmp_a),
        .cmp_b   (cmp_b),
        .ctrl    (ctrl)
    );

    pwm_ds_counter #(.W(W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .top         (top),
        .cnt         (cnt),
        .head_up     (head_up),
        .bottom_tick (bottom_tick)
    );

    assign ch_cmp[0]  = cmp_a;
    assign ch_cmp[1]  = cmp_b;
    assign ch_mode[0] = ctrl.mode_a;
    assign ch_mode[1] = ctrl.mode_b;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_ds_wave #(.W(W), .IS_A(g == 0)) u_wave (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tick),
            .cnt        (cnt),
            .cmp        (ch_cmp[g]),
            .mode       (ch_mode[g]),
            .top_from_a (ctrl.top_src),
            .head_up    (head_up),
            .wave       (ch_wave[g])
        );
    end

    assign wave_a = ch_wave[0];
    assign wave_b = ch_wave[1];

endmodule

// File: tb/pwm_dual_slope_tb.sv
`timescale 1ns/1ps
module pwm_dual_slope_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        wave_a;
    logic        wave_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwm_dual_slope u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .wave_a(wave_a), .wave_b(wave_b)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // n enabled ticks; counts high samples taken after each tick
    task automatic run(input int n, output int ha, output int hb);
        ha = 0; hb = 0;
        @(negedge clk);
        tick = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ha += int'(wave_a);
            hb += int'(wave_b);
        end
        tick = 1'b0;
    endtask

    task automatic t_reset();
        int ha, hb;
        do_reset();
        chk("R1 wave_a after reset", int'(wave_a), 0);
        chk("R1 wave_b after reset", int'(wave_b), 0);
        run(40, ha, hb);
        chk("R1 default config keeps outputs low", ha + hb, 0);
    endtask

    task automatic t_noninv();
        int ha, hb;
        do_reset();
        wr(2'd0, 16'd9); wr(2'd1, 16'd2); wr(2'd2, 16'd4); wr(2'd3, 16'h000A); // R3 map
        run(50, ha, hb);
        run(18, ha, hb);
        chk("R4 A high ticks, TOP 9 cmp 2", ha, 4);
        chk("R4 B high ticks, TOP 9 cmp 4", hb, 8);
    endtask

    task automatic t_inv();
        int ha, hb;
        do_reset();
        wr(2'd0, 16'd12); wr(2'd1, 16'd5); wr(2'd2, 16'd9); wr(2'd3, 16'h000F);
        run(50, ha, hb);
        run(24, ha, hb);
        chk("R5 A high ticks, TOP 12 cmp 5", ha, 14);
        chk("R5 B high ticks, TOP 12 cmp 9", hb, 6);
    endtask

    task automatic t_extremes();
        int ha, hb;
        do_reset();
        wr(2'd0, 16'd10); wr(2'd1, 16'd0); wr(2'd2, 16'd10); wr(2'd3, 16'h000A);
        run(50, ha, hb);
        run(20, ha, hb);
        chk("R6 mode 2 cmp 0 always low", ha, 0);
        chk("R6 mode 2 cmp TOP always high", hb, 20);
        wr(2'd3, 16'h000F);
        run(50, ha, hb);
        run(20, ha, hb);
        chk("R6 mode 3 cmp 0 always high", ha, 20);
        chk("R6 mode 3 cmp TOP always low", hb, 0);
    endtask

    task automatic t_toggle();
        int ha, hb;
        do_reset();
        wr(2'd0, 16'd20); wr(2'd1, 16'd6); wr(2'd2, 16'd3); wr(2'd3, 16'h0019);
        run(50, ha, hb);
        run(12, ha, hb);
        chk("R7 B duty with TOP taken from compare A", hb, 6);
        run(24, ha, hb);
        chk("R7 A toggle high ticks per 4*TOP", ha, 12);
    endtask

    task automatic t_buffer();
        int ha, hb;
        do_reset();
        wr(2'd0, 16'd9); wr(2'd2, 16'd4); wr(2'd3, 16'h0008);
        run(3, ha, hb);
        wr(2'd2, 16'd8);
        run(11, ha, hb);
        chk("R8 old compare still in use at tick 14", int'(wave_b), 0);
        run(1, ha, hb);
        chk("R8 set at old compare on falling slope, tick 15", int'(wave_b), 1);
        repeat (20) @(negedge clk);
        chk("R2 output holds while tick low", int'(wave_b), 1);
        run(11, ha, hb);
        chk("R2 no early clear, tick 26", int'(wave_b), 1);
        run(1, ha, hb);
        chk("R8 new compare clears on rising slope, tick 27", int'(wave_b), 0);
        run(2, ha, hb);
        chk("R2 reversal at TOP without repeat, tick 29", int'(wave_b), 1);
    endtask

    task automatic t_ignored();
        int ha, hb;
        do_reset();
        wr(2'd1, 16'd5); wr(2'd2, 16'd3); wr(2'd3, 16'h0016);
        run(60, ha, hb);
        chk("R9 A mode 2 ignored with TOP from compare A", ha, 0);
        chk("R9 B mode 1 ignored", hb, 0);
        do_reset();
        wr(2'd0, 16'd8); wr(2'd2, 16'd8); wr(2'd3, 16'h0008);
        run(50, ha, hb);
        run(16, ha, hb);
        chk("R6 B high before disconnect", hb, 16);
        wr(2'd2, 16'd3); wr(2'd3, 16'h0000);
        run(50, ha, hb);
        run(40, ha, hb);
        chk("R9 mode 0 holds high level", hb, 40);
    endtask

    initial begin
        t_reset();
        t_noninv();
        t_inv();
        t_extremes();
        t_toggle();
        t_buffer();
        t_ignored();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule